// File: doc/BRIEF.md
# NAND Plane Operation Sequencer

This block steps one plane of a single-level-cell NAND array through the bias phases of its three basic operations. A command (read, program or erase) comes in over a valid/ready handshake, together with a block address, a page address and the number of 1 bits in the page. The sequencer then walks through its phases. In each phase it drives abstract bias codes onto the selected word-line, the unselected word-lines, the three select lines (string, ground and source), the bit-lines and the well. The analog side turns these codes into real voltages. The analog generators and the cell array are outside this block. The only feedback from them is a single pass/fail verify input.

Program runs a loop: one pulse, then one verify read. The loop ends when a verify passes or when a per-command loop limit is reached. Erase applies one erase pulse to the whole block and then does exactly one verify read. Every operation ends back in precharge, where the next command can be accepted. Three event counters run from reset: program pulses, verify reads, and bit-lines discharged by reads. They give a power model the raw event counts it needs.

Top module: `nandseq_top`

## Requirements
- R1: While reset is held, the block is idle. `cmdReady` is 0 and every bias output is ground (code 0). The first clock after reset is released moves the block to precharge. In precharge the bit-line outputs carry the precharge code 1, the word-line, select-line and well outputs are ground, and `cmdReady` is 1. All counters, `done` and `fail` reset to 0.
- R2: A command is taken on a rising edge where `cmdValid` and `cmdReady` are both 1. `cmdReady` is 1 only in precharge and stays 0 for the whole of an operation. Opcode 0 is read, 1 is program and 2 is erase. Opcode 3 is taken and dropped: it causes no phase, no counter change and no `done`.
- R3: During read, `wlSelBias` is ground (0), `wlUnselBias`, `sslBias`, `gslBias` and `slBias` carry the read level (2), and both bit-line outputs stay at precharge (1). `pageEn` is 1, and `selBlock`/`selPage` show the latched address.
- R4: Each accepted read adds `cmdOnes` to `dischargeCount`, which wraps modulo 2^DIS_W.
- R5: During a program pulse, `wlSelBias` is the program level (3), `wlUnselBias` is pass (4) and `sslBias` is supply (5). `gslBias` and `slBias` are ground. `blOneBias` is inhibit (6), `blZeroBias` is ground, and `pageEn` is 1.
- R6: Program alternates one pulse and one verify read; the verify uses the R3 bias set. The loop ends with `fail`=0 on the first verify where `verifyPass` is 1. It ends with `fail`=1 when the number of pulses reaches the `maxLoops` value latched at acceptance without a pass; a `maxLoops` of 0 counts as 1.
- R7: During the erase pulse, both word-line outputs are ground. `wellBias` is erase (7), `sslBias` and `gslBias` are coupled (8), and `slBias` and both bit-line outputs are erase bit-line (9). `pageEn` is 0 and `selPage` is 0.
- R8: Erase is followed by exactly one verify read. `fail` is the inverse of `verifyPass` sampled in the last cycle of that verify.
- R9: Each phase lasts its programmed cycle count (`tRead`, `tPulse`, `tVerify`, `tErase`); a count of 0 acts as 1. Counting from the accept edge, `done` is seen after tRead+1 cycles for a read, k·(tPulse+tVerify)+1 cycles for a program with k pulses, and tErase+tVerify+1 cycles for an erase.
- R10: `done` is high for exactly one cycle, the first cycle back in precharge. `fail` is updated on that cycle and held until the next `done`. A read always reports `fail`=0.
- R11: `pulseCount` goes up by one per program pulse. `verifyCount` goes up by one per verify read, for both program and erase. Both saturate at 2^CTR_W−1 and do not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Command can be taken (precharge only) |
| cmdOp | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| cmdBlock | input | BLOCK_W | Block address |
| cmdPage | input | PAGE_W | Page address within block |
| cmdOnes | input | ONES_W | Number of 1 bits in the page |
| maxLoops | input | 4 | Program loop limit, 0 treated as 1 |
| tRead | input | TIME_W | Read phase length in cycles |
| tPulse | input | TIME_W | Program pulse length in cycles |
| tVerify | input | TIME_W | Verify read length in cycles |
| tErase | input | TIME_W | Erase pulse length in cycles |
| verifyPass | input | 1 | Verify result, sampled in last verify cycle |
| wlSelBias | output | 4 | Selected word-line bias code |
| wlUnselBias | output | 4 | Unselected word-line bias code |
| sslBias | output | 4 | String select line bias code |
| gslBias | output | 4 | Ground select line bias code |
| slBias | output | 4 | Source line bias code |
| blOneBias | output | 4 | Bias for bit-lines whose data bit is 1 |
| blZeroBias | output | 4 | Bias for bit-lines whose data bit is 0 |
| wellBias | output | 4 | Well bias code |
| selBlock | output | BLOCK_W | Active block decode |
| selPage | output | PAGE_W | Active page decode (0 when pageEn is 0) |
| pageEn | output | 1 | Page decode in use |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result of the last completed operation |
| pulseCount | output | CTR_W | Saturating program pulse count |
| verifyCount | output | CTR_W | Saturating verify read count |
| dischargeCount | output | DIS_W | Accumulated discharged bit-lines |

## Verification
The bench targets the loop exit on the exact pass verify, the loop limit of 0 that must still give one pulse, and the limit of 15 that must not cut off early. A sequencer with an off-by-one in loop counting would report the wrong pulse count and latency, or a false fail. It drives a command while busy and the reserved opcode. A design that did not gate acceptance would start a second operation and move the counters. Zero-length phases and counter saturation are forced: a design that wrapped would show small counts after many failed programs, and one that honoured a zero length literally would hang or skip a phase.

// File: rtl/nandseq_pkg.sv
package nandseq_pkg;

  typedef enum logic [3:0] {
    BIAS_GND        = 4'd0,
    BIAS_PRECH      = 4'd1,
    BIAS_READ       = 4'd2,
    BIAS_PROG       = 4'd3,
    BIAS_PASS       = 4'd4,
    BIAS_SUPPLY     = 4'd5,
    BIAS_INHIBIT    = 4'd6,
    BIAS_WELL_ERASE = 4'd7,
    BIAS_COUPLED    = 4'd8,
    BIAS_ERASE_BL   = 4'd9
  } bias_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRECH, PH_READ, PH_PULSE, PH_VERIFY, PH_ERASE, PH_EVERIFY
  } phase_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_PROG  = 2'd1;
  localparam logic [1:0] OP_ERASE = 2'd2;

  typedef struct packed {
    logic latchCmd;
    logic addOnes;
    logic incPulse;
    logic incVerify;
  } strobe_t;

endpackage

// File: rtl/nandseq_ctrl.sv
module nandseq_ctrl
  import nandseq_pkg::*;
#(
  parameter int TIME_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [3:0]        maxLoops,
  input  logic [TIME_W-1:0] tRead,
  input  logic [TIME_W-1:0] tPulse,
  input  logic [TIME_W-1:0] tVerify,
  input  logic [TIME_W-1:0] tErase,
  input  logic              verifyPass,
  output logic              cmdReady,
  output phase_e            phase,
  output strobe_t           strobe,
  output logic              done,
  output logic              fail
);

  phase_e            nextPhase;
  logic [TIME_W-1:0] timer, nextTimer;
  logic [3:0]        loopCnt, nextLoop, loopLimit, nextLimit;
  logic              finish, finFail;
  logic              lastCycle;

  function automatic logic [TIME_W-1:0] loadLen(input logic [TIME_W-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign lastCycle = (timer == '0);
  assign cmdReady  = (phase == PH_PRECH);

  always_comb begin
    nextPhase = phase;
    nextTimer = lastCycle ? timer : timer - 1'b1;
    nextLoop  = loopCnt;
    nextLimit = loopLimit;
    finish    = 1'b0;
    finFail   = 1'b0;
    strobe    = '0;
    case (phase)
      PH_IDLE: nextPhase = PH_PRECH;
      PH_PRECH: begin
        if (cmdValid) begin
          strobe.latchCmd = 1'b1;
          if (cmdOp == OP_READ) begin
            nextPhase      = PH_READ;
            nextTimer      = loadLen(tRead);
            strobe.addOnes = 1'b1;
          end else if (cmdOp == OP_PROG) begin
            nextPhase       = PH_PULSE;
            nextTimer       = loadLen(tPulse);
            strobe.incPulse = 1'b1;
            nextLoop        = 4'd1;
            nextLimit       = (maxLoops == 4'd0) ? 4'd1 : maxLoops;
          end else if (cmdOp == OP_ERASE) begin
            nextPhase = PH_ERASE;
            nextTimer = loadLen(tErase);
          end
        end
      end
      PH_READ: if (lastCycle) begin
        nextPhase = PH_PRECH;
        finish    = 1'b1;
      end
      PH_PULSE: if (lastCycle) begin
        nextPhase        = PH_VERIFY;
        nextTimer        = loadLen(tVerify);
        strobe.incVerify = 1'b1;
      end
      PH_VERIFY: if (lastCycle) begin
        if (verifyPass) begin
          nextPhase = PH_PRECH;
          finish    = 1'b1;
        end else if (loopCnt >= loopLimit) begin
          nextPhase = PH_PRECH;
          finish    = 1'b1;
          finFail   = 1'b1;
        end else begin
          nextPhase       = PH_PULSE;
          nextTimer       = loadLen(tPulse);
          strobe.incPulse = 1'b1;
          nextLoop        = loopCnt + 4'd1;
        end
      end
      PH_ERASE: if (lastCycle) begin
        nextPhase        = PH_EVERIFY;
        nextTimer        = loadLen(tVerify);
        strobe.incVerify = 1'b1;
      end
      PH_EVERIFY: if (lastCycle) begin
        nextPhase = PH_PRECH;
        finish    = 1'b1;
        finFail   = !verifyPass;
      end
      default: nextPhase = PH_PRECH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      timer     <= '0;
      loopCnt   <= '0;
      loopLimit <= 4'd1;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      phase     <= nextPhase;
      timer     <= nextTimer;
      loopCnt   <= nextLoop;
      loopLimit <= nextLimit;
      done      <= finish;
      if (finish) fail <= finFail;
    end
  end

  // R10: completion pulse never stretches
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: a real opcode taken in precharge leaves precharge
  assert_accept_moves_R2: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PRECH && cmdValid && cmdOp != 2'd3) |=> (phase != PH_PRECH));

  // R6: pulse index stays within the latched limit
  assert_loop_cap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PULSE) |-> (loopCnt >= 4'd1 && loopCnt <= loopLimit));

  // R6: every pulse ends in a verify
  assert_verify_follows_R6: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_PULSE && lastCycle) |=> (phase == PH_VERIFY));

endmodule

// File: rtl/nandseq_dp.sv
module nandseq_dp
  import nandseq_pkg::*;
#(
  parameter int BLOCK_W = 4,
  parameter int PAGE_W  = 3,
  parameter int ONES_W  = 7,
  parameter int CTR_W   = 8,
  parameter int DIS_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  phase_e             phase,
  input  strobe_t            strobe,
  input  logic [BLOCK_W-1:0] cmdBlock,
  input  logic [PAGE_W-1:0]  cmdPage,
  input  logic [ONES_W-1:0]  cmdOnes,
  output logic [3:0]         wlSelBias,
  output logic [3:0]         wlUnselBias,
  output logic [3:0]         sslBias,
  output logic [3:0]         gslBias,
  output logic [3:0]         slBias,
  output logic [3:0]         blOneBias,
  output logic [3:0]         blZeroBias,
  output logic [3:0]         wellBias,
  output logic [BLOCK_W-1:0] selBlock,
  output logic [PAGE_W-1:0]  selPage,
  output logic               pageEn,
  output logic [CTR_W-1:0]   pulseCount,
  output logic [CTR_W-1:0]   verifyCount,
  output logic [DIS_W-1:0]   dischargeCount
);

  localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};

  logic [BLOCK_W-1:0] blockQ;
  logic [PAGE_W-1:0]  pageQ;
  logic               active;

  assign active   = (phase != PH_IDLE) && (phase != PH_PRECH);
  assign pageEn   = (phase == PH_READ) || (phase == PH_PULSE) || (phase == PH_VERIFY);
  assign selBlock = active ? blockQ : '0;
  assign selPage  = pageEn ? pageQ : '0;

  always_comb begin
    wlSelBias   = BIAS_GND;
    wlUnselBias = BIAS_GND;
    sslBias     = BIAS_GND;
    gslBias     = BIAS_GND;
    slBias      = BIAS_GND;
    blOneBias   = BIAS_GND;
    blZeroBias  = BIAS_GND;
    wellBias    = BIAS_GND;
    case (phase)
      PH_PRECH: begin
        blOneBias  = BIAS_PRECH;
        blZeroBias = BIAS_PRECH;
      end
      PH_READ, PH_VERIFY, PH_EVERIFY: begin
        wlUnselBias = BIAS_READ;
        sslBias     = BIAS_READ;
        gslBias     = BIAS_READ;
        slBias      = BIAS_READ;
        blOneBias   = BIAS_PRECH;
        blZeroBias  = BIAS_PRECH;
      end
      PH_PULSE: begin
        wlSelBias   = BIAS_PROG;
        wlUnselBias = BIAS_PASS;
        sslBias     = BIAS_SUPPLY;
        blOneBias   = BIAS_INHIBIT;
      end
      PH_ERASE: begin
        wellBias   = BIAS_WELL_ERASE;
        sslBias    = BIAS_COUPLED;
        gslBias    = BIAS_COUPLED;
        slBias     = BIAS_ERASE_BL;
        blOneBias  = BIAS_ERASE_BL;
        blZeroBias = BIAS_ERASE_BL;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      blockQ         <= '0;
      pageQ          <= '0;
      pulseCount     <= '0;
      verifyCount    <= '0;
      dischargeCount <= '0;
    end else begin
      if (strobe.latchCmd) begin
        blockQ <= cmdBlock;
        pageQ  <= cmdPage;
      end
      if (strobe.addOnes)
        dischargeCount <= dischargeCount + DIS_W'(cmdOnes);
      if (strobe.incPulse && pulseCount != CTR_MAX)
        pulseCount <= pulseCount + 1'b1;
      if (strobe.incVerify && verifyCount != CTR_MAX)
        verifyCount <= verifyCount + 1'b1;
    end
  end

  // R11: saturated counters stay saturated
  assert_pulse_sat_R11: assert property (@(posedge clk) disable iff (!rstN)
    (pulseCount == CTR_MAX) |=> (pulseCount == CTR_MAX));

  assert_verify_sat_R11: assert property (@(posedge clk) disable iff (!rstN)
    (verifyCount == CTR_MAX) |=> (verifyCount == CTR_MAX));

  // R4: a read start adds the page's 1 count
  assert_ones_add_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.addOnes |=> (dischargeCount == $past(dischargeCount) + DIS_W'($past(cmdOnes))));

  // R7: erase never drives a page decode
  assert_erase_no_page_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ERASE) |-> (selPage == '0 && wlSelBias == 4'd0));

endmodule

// File: rtl/nandseq_top.sv
module nandseq_top
  import nandseq_pkg::*;
#(
  parameter int BLOCK_W   = 4,
  parameter int PAGE_W    = 3,
  parameter int PAGE_BITS = 64,
  parameter int ONES_W    = $clog2(PAGE_BITS + 1),
  parameter int TIME_W    = 8,
  parameter int CTR_W     = 8,
  parameter int DIS_W     = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  output logic               cmdReady,
  input  logic [1:0]         cmdOp,
  input  logic [BLOCK_W-1:0] cmdBlock,
  input  logic [PAGE_W-1:0]  cmdPage,
  input  logic [ONES_W-1:0]  cmdOnes,
  input  logic [3:0]         maxLoops,
  input  logic [TIME_W-1:0]  tRead,
  input  logic [TIME_W-1:0]  tPulse,
  input  logic [TIME_W-1:0]  tVerify,
  input  logic [TIME_W-1:0]  tErase,
  input  logic               verifyPass,
  output logic [3:0]         wlSelBias,
  output logic [3:0]         wlUnselBias,
  output logic [3:0]         sslBias,
  output logic [3:0]         gslBias,
  output logic [3:0]         slBias,
  output logic [3:0]         blOneBias,
  output logic [3:0]         blZeroBias,
  output logic [3:0]         wellBias,
  output logic [BLOCK_W-1:0] selBlock,
  output logic [PAGE_W-1:0]  selPage,
  output logic               pageEn,
  output logic               done,
  output logic               fail,
  output logic [CTR_W-1:0]   pulseCount,
  output logic [CTR_W-1:0]   verifyCount,
  output logic [DIS_W-1:0]   dischargeCount
);

  phase_e  phase;
  strobe_t strobe;

  nandseq_ctrl #(.TIME_W(TIME_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .maxLoops(maxLoops), .tRead(tRead), .tPulse(tPulse), .tVerify(tVerify),
    .tErase(tErase), .verifyPass(verifyPass), .cmdReady(cmdReady),
    .phase(phase), .strobe(strobe), .done(done), .fail(fail)
  );

  nandseq_dp #(
    .BLOCK_W(BLOCK_W), .PAGE_W(PAGE_W), .ONES_W(ONES_W),
    .CTR_W(CTR_W), .DIS_W(DIS_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .phase(phase), .strobe(strobe),
    .cmdBlock(cmdBlock), .cmdPage(cmdPage), .cmdOnes(cmdOnes),
    .wlSelBias(wlSelBias), .wlUnselBias(wlUnselBias), .sslBias(sslBias),
    .gslBias(gslBias), .slBias(slBias), .blOneBias(blOneBias),
    .blZeroBias(blZeroBias), .wellBias(wellBias), .selBlock(selBlock),
    .selPage(selPage), .pageEn(pageEn), .pulseCount(pulseCount),
    .verifyCount(verifyCount), .dischargeCount(dischargeCount)
  );

endmodule

// File: tb/nandseq_top_tb.sv
module nandseq_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [1:0]  cmdOp = 2'd0;
  logic [3:0]  cmdBlock = '0;
  logic [2:0]  cmdPage = '0;
  logic [6:0]  cmdOnes = '0;
  logic [3:0]  maxLoops = 4'd1;
  logic [7:0]  tRead = 8'd3, tPulse = 8'd2, tVerify = 8'd2, tErase = 8'd4;
  logic        verifyPass = 1'b0;
  logic [3:0]  wlSelBias, wlUnselBias, sslBias, gslBias, slBias;
  logic [3:0]  blOneBias, blZeroBias, wellBias;
  logic [3:0]  selBlock;
  logic [2:0]  selPage;
  logic        pageEn, done, fail;
  logic [7:0]  pulseCount, verifyCount;
  logic [15:0] dischargeCount;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  nandseq_top u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdOp(cmdOp), .cmdBlock(cmdBlock), .cmdPage(cmdPage), .cmdOnes(cmdOnes),
    .maxLoops(maxLoops), .tRead(tRead), .tPulse(tPulse), .tVerify(tVerify),
    .tErase(tErase), .verifyPass(verifyPass), .wlSelBias(wlSelBias),
    .wlUnselBias(wlUnselBias), .sslBias(sslBias), .gslBias(gslBias),
    .slBias(slBias), .blOneBias(blOneBias), .blZeroBias(blZeroBias),
    .wellBias(wellBias), .selBlock(selBlock), .selPage(selPage),
    .pageEn(pageEn), .done(done), .fail(fail), .pulseCount(pulseCount),
    .verifyCount(verifyCount), .dischargeCount(dischargeCount)
  );

  typedef struct packed {
    logic [1:0] op;
    logic [6:0] ones;
    logic [3:0] maxl;
    logic [3:0] passAt;
    logic [7:0] expP;
    logic [7:0] expV;
    logic       expFail;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{op:2'd0, ones:7'd10, maxl:4'd1,  passAt:4'd0,  expP:8'd0,  expV:8'd0,  expFail:1'b0},
    '{op:2'd0, ones:7'd64, maxl:4'd1,  passAt:4'd0,  expP:8'd0,  expV:8'd0,  expFail:1'b0},
    '{op:2'd1, ones:7'd0,  maxl:4'd4,  passAt:4'd1,  expP:8'd1,  expV:8'd1,  expFail:1'b0},
    '{op:2'd1, ones:7'd0,  maxl:4'd4,  passAt:4'd3,  expP:8'd3,  expV:8'd3,  expFail:1'b0},
    '{op:2'd1, ones:7'd0,  maxl:4'd2,  passAt:4'd0,  expP:8'd2,  expV:8'd2,  expFail:1'b1},
    '{op:2'd1, ones:7'd0,  maxl:4'd0,  passAt:4'd0,  expP:8'd1,  expV:8'd1,  expFail:1'b1},
    '{op:2'd2, ones:7'd0,  maxl:4'd1,  passAt:4'd1,  expP:8'd0,  expV:8'd1,  expFail:1'b0},
    '{op:2'd2, ones:7'd0,  maxl:4'd1,  passAt:4'd0,  expP:8'd0,  expV:8'd1,  expFail:1'b1},
    '{op:2'd1, ones:7'd0,  maxl:4'd15, passAt:4'd15, expP:8'd15, expV:8'd15, expFail:1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Offer a command; returns cycles from accept edge until done is seen.
  task automatic runCmd(input logic [1:0] op, input logic [3:0] blk, input logic [2:0] pg,
                        input logic [6:0] ones, input logic [3:0] maxl,
                        input logic [3:0] passAt, output int lat);
    logic [7:0] base;
    base = pulseCount;
    cmdOp = op; cmdBlock = blk; cmdPage = pg; cmdOnes = ones; maxLoops = maxl;
    cmdValid = 1'b1;
    while (!cmdReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 1;
    while (!done && lat < 2000) begin
      verifyPass = (passAt != 0) && (op == 2'd2 || (8'(pulseCount - base) >= 8'(passAt)));
      @(negedge clk);
      lat++;
    end
    verifyPass = 1'b0;
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    finishRun();
  end

  initial begin
    int lat;
    int dis;
    logic [7:0] p0, v0;
    logic [15:0] d0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", cmdReady, 0);
    chk("R1 bl bias in reset", blOneBias, 0);
    chk("R1 wl bias in reset", wlUnselBias, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready in precharge", cmdReady, 1);
    chk("R1 bl one precharge", blOneBias, 1);
    chk("R1 bl zero precharge", blZeroBias, 1);
    chk("R1 select ground", sslBias + gslBias + slBias + wellBias + wlSelBias + wlUnselBias, 0);
    chk("R1 counters zero", pulseCount + verifyCount + dischargeCount, 0);
    chk("R1 done fail zero", done + fail, 0);

    // Vector walk: R4 R6 R8 R9 R11 R10
    dis = 0;
    foreach (VEC[i]) begin
      p0 = pulseCount; v0 = verifyCount;
      runCmd(VEC[i].op, 4'd1, 3'd2, VEC[i].ones, VEC[i].maxl, VEC[i].passAt, lat);
      if (VEC[i].op == 2'd0) dis += VEC[i].ones;
      chk($sformatf("R6 R11 pulses vec%0d", i), 8'(pulseCount - p0), VEC[i].expP);
      chk($sformatf("R8 R11 verifies vec%0d", i), 8'(verifyCount - v0), VEC[i].expV);
      chk($sformatf("R6 R8 R10 fail vec%0d", i), fail, VEC[i].expFail);
      chk($sformatf("R4 discharge vec%0d", i), dischargeCount, dis);
      if (VEC[i].op == 2'd0)      chk($sformatf("R9 read latency vec%0d", i), lat, 3 + 1);
      else if (VEC[i].op == 2'd1) chk($sformatf("R9 prog latency vec%0d", i), lat, VEC[i].expP * 4 + 1);
      else                        chk($sformatf("R9 erase latency vec%0d", i), lat, 4 + 2 + 1);
    end

    // R10: done lasts one cycle
    @(negedge clk);
    chk("R10 done single cycle", done, 0);

    // R3 and R2: read biases, busy hold-off
    d0 = dischargeCount; v0 = verifyCount;
    cmdOp = 2'd0; cmdBlock = 4'd5; cmdPage = 3'd6; cmdOnes = 7'd7; cmdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmdOp = 2'd2;
    chk("R3 read sel wl", wlSelBias, 0);
    chk("R3 read unsel wl", wlUnselBias, 2);
    chk("R3 read ssl", sslBias, 2);
    chk("R3 read gsl", gslBias, 2);
    chk("R3 read sl", slBias, 2);
    chk("R3 read bl", blZeroBias, 1);
    chk("R3 read block", selBlock, 5);
    chk("R3 read page", selPage, 6);
    chk("R3 read pageEn", pageEn, 1);
    chk("R2 ready busy", cmdReady, 0);
    @(negedge clk);
    chk("R2 ready still busy", cmdReady, 0);
    cmdValid = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    repeat (12) @(negedge clk);
    chk("R2 busy command dropped", verifyCount, v0);
    chk("R4 single read added", dischargeCount, d0 + 7);

    // R5 and R6: pulse biases, verify reuses read biases
    cmdOp = 2'd1; cmdBlock = 4'd2; cmdPage = 3'd3; maxLoops = 4'd1; cmdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
    chk("R5 pulse sel wl", wlSelBias, 3);
    chk("R5 pulse unsel wl", wlUnselBias, 4);
    chk("R5 pulse ssl", sslBias, 5);
    chk("R5 pulse gsl sl", gslBias + slBias, 0);
    chk("R5 pulse bl one", blOneBias, 6);
    chk("R5 pulse bl zero", blZeroBias, 0);
    chk("R5 pulse page", selPage, 3);
    @(negedge clk); @(negedge clk);
    verifyPass = 1'b1;
    chk("R6 verify unsel wl", wlUnselBias, 2);
    chk("R6 verify sel wl", wlSelBias, 0);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    verifyPass = 1'b0;
    chk("R6 pass result", fail, 0);

    // R7: erase biases
    cmdOp = 2'd2; cmdBlock = 4'd9; cmdPage = 3'd5; cmdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 erase well", wellBias, 7);
    chk("R7 erase ssl", sslBias, 8);
    chk("R7 erase gsl", gslBias, 8);
    chk("R7 erase sl", slBias, 9);
    chk("R7 erase bl", blOneBias + blZeroBias, 18);
    chk("R7 erase wl", wlSelBias + wlUnselBias, 0);
    chk("R7 erase no page", pageEn + selPage, 0);
    chk("R7 erase block", selBlock, 9);
    lat = 0;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    chk("R8 erase no pass fails", fail, 1);

    // R10: fail held; R2: reserved opcode dropped
    p0 = pulseCount; v0 = verifyCount; d0 = dischargeCount;
    cmdOp = 2'd3; cmdOnes = 7'd9; cmdValid = 1'b1;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0;
    chk("R2 reserved keeps ready", cmdReady, 1);
    lat = 0;
    repeat (10) begin @(negedge clk); if (done) lat++; end
    chk("R2 reserved no done", lat, 0);
    chk("R2 reserved no count", dischargeCount + pulseCount + verifyCount, d0 + p0 + v0);
    chk("R10 fail held", fail, 1);

    // R9: zero length acts as one
    tRead = 8'd0;
    runCmd(2'd0, 4'd0, 3'd0, 7'd0, 4'd1, 4'd0, lat);
    chk("R9 zero length read", lat, 2);
    chk("R10 read clears fail", fail, 0);
    tRead = 8'd3;

    // R11: saturation
    tPulse = 8'd1; tVerify = 8'd1;
    repeat (18) runCmd(2'd1, 4'd0, 3'd0, 7'd0, 4'd15, 4'd0, lat);
    chk("R11 pulse saturates", pulseCount, 255);
    chk("R11 verify saturates", verifyCount, 255);

    finishRun();
  end

endmodule